// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Sense Unit

This block turns the synchronised pad levels of a GPIO bank into a vector of interrupt status bits, one bit per line. Each line has its own settings: whether it is in interrupt mode, whether it senses a level or an edge, which polarity is active, and whether both transitions count. Edge events are latched until software clears them with a write-1-to-clear pulse. Level events are not latched, so the status bit shows the active level directly.

Edges are found by comparing each line's current level with a copy of that level taken on the previous clock. The copy is updated on every cycle, including during reset and while the line is out of interrupt mode. Because of this, turning a line's interrupt mode back on never shows an edge that happened while it was off. Masking, register access and combining the status bits into one request are handled outside this block.

Top module: `gpio_irq_sense`

## Requirements
- R1: With edge sensing selected (edge bit = 1), polarity bit = 0 and both-edge bit = 0, a 0-to-1 change on an enabled line sets its status bit. The bit becomes visible after the clock edge that samples the new level.
- R2: With edge sensing selected and polarity bit = 1 (both-edge bit = 0), a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R3: With edge sensing selected and both-edge bit = 1, either transition sets the status bit, whatever the polarity bit holds.
- R4: A latched edge status bit stays set until a clear pulse (clear bit = 1) is sampled on that line. It then reads 0 from the next cycle onward.
- R5: If a qualifying edge and a clear pulse are sampled on the same line in the same cycle, the status bit is set afterwards.
- R6: With level sensing selected (edge bit = 0), the status bit equals the pin level XOR the polarity bit in the same cycle, with no register delay. A clear pulse has no effect on it.
- R7: A line whose interrupt-mode bit is 0 reads status 0 in the same cycle, and its latched edge state is discarded. When it is re-enabled, transitions that happened while it was disabled set nothing.
- R8: During reset, and on the first cycle after it, every edge-sensed status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_lvl | input | LINES | Synchronised pad levels |
| irq_mode | input | LINES | 1 = line is in interrupt mode |
| act_low | input | LINES | 1 = active-low level or falling edge |
| edge_mode | input | LINES | 1 = edge sensing, 0 = level sensing |
| any_edge | input | LINES | 1 = both transitions count (edge sensing only) |
| clr_pulse | input | LINES | Write-1-to-clear pulse for each line |
| irq_status | output | LINES | Status bit for each line |

## Verification
Level-sensed results and the disable gating are combinational. The bench checks them in the same cycle the inputs change, a short delay after driving them. Edge results and clears pass through one register, so the bench drives inputs on the falling clock edge, lets one rising edge sample them, and compares on the next falling edge. A bench model is advanced on each rising edge from the same sampled inputs, so every comparison waits exactly one register stage. Random traffic and directed sequences both follow this schedule.

// File: rtl/gpio_sense_pkg.sv
// Package: shared helpers for the per-line interrupt sense unit.
// Assumes: callers pass single-line values already sampled on the clock.
package gpio_sense_pkg;

    // Decide whether a line's transition qualifies as an interrupt edge.
    function automatic logic edge_hit(
        input logic rise,
        input logic fall,
        input logic low_act,
        input logic both
    );
        if (both)
            return rise | fall;
        else if (low_act)
            return fall;
        else
            return rise;
    endfunction

endpackage

// File: rtl/sense_edge_det.sv
// Module: sense_edge_det
// Keeps the previous level of every line and reports rising and falling
// changes relative to it. The previous-level register loads every cycle,
// during reset too, so no false edge appears after reset or re-enable.
// Assumes: pad levels are already synchronised to clk.
module sense_edge_det #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] lvl_q;

    // Record each line's level for the next cycle's comparison.
    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    // Compare the current and previous levels line by line.
    always_comb begin
        rise = lvl & ~lvl_q;
        fall = ~lvl & lvl_q;
    end
endmodule

// File: rtl/sense_line_cell.sv
// Module: sense_line_cell
// Sense logic for one line: an edge latch with set-over-clear priority,
// plus the level path. Returns the gated status bit.
// Assumes: rise/fall come from sense_edge_det on the same clock.
module sense_line_cell
    import gpio_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise,
    input  logic fall,
    input  logic en,
    input  logic low_act,
    input  logic edg,
    input  logic both,
    input  logic clr,
    output logic status
);
    logic latch_q;
    logic hit;

    // Qualify the current transition against this line's settings.
    always_comb begin
        hit = en & edg & edge_hit(rise, fall, low_act, both);
    end

    // Edge latch: a new hit wins over a clear; leaving edge mode empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= 1'b0;
        else if (!(en && edg))
            latch_q <= 1'b0;
        else if (hit)
            latch_q <= 1'b1;
        else if (clr)
            latch_q <= 1'b0;
    end

    // Choose the latched or level status, then gate it with interrupt mode.
    always_comb begin
        status = en & (edg ? latch_q : (lvl ^ low_act));
    end
endmodule

// File: rtl/gpio_irq_sense.sv
// Module: gpio_irq_sense (top)
// Detects interrupts for each line of a GPIO bank with its own polarity,
// level/edge and both-edge settings. Edge events are held until cleared;
// level events follow the pin.
// Assumes: every input is synchronous to clk; masking is done elsewhere.
module gpio_irq_sense #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pad_lvl,
    input  logic [LINES-1:0] irq_mode,
    input  logic [LINES-1:0] act_low,
    input  logic [LINES-1:0] edge_mode,
    input  logic [LINES-1:0] any_edge,
    input  logic [LINES-1:0] clr_pulse,
    output logic [LINES-1:0] irq_status
);
    logic [LINES-1:0] rise_v;
    logic [LINES-1:0] fall_v;

    sense_edge_det #(.WIDTH(LINES)) u_edge (
        .clk  (clk),
        .lvl  (pad_lvl),
        .rise (rise_v),
        .fall (fall_v)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        sense_line_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (pad_lvl[g]),
            .rise    (rise_v[g]),
            .fall    (fall_v[g]),
            .en      (irq_mode[g]),
            .low_act (act_low[g]),
            .edg     (edge_mode[g]),
            .both    (any_edge[g]),
            .clr     (clr_pulse[g]),
            .status  (irq_status[g])
        );
    end
endmodule

// File: rtl/gpio_irq_sense_chk.sv
// Module: gpio_irq_sense_chk
// Property checker for gpio_irq_sense, attached with bind below.
// Assumes: inputs are held steady around the rising clock edge.
module gpio_irq_sense_chk #(
    parameter int LINES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] pad_lvl,
    input logic [LINES-1:0] irq_mode,
    input logic [LINES-1:0] act_low,
    input logic [LINES-1:0] edge_mode,
    input logic [LINES-1:0] any_edge,
    input logic [LINES-1:0] clr_pulse,
    input logic [LINES-1:0] irq_status
);
    for (genvar i = 0; i < LINES; i++) begin : g_chk
        // R1: a rising edge sets the status of a single-edge, active-high edge line
        p_rise_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && edge_mode[i] && !act_low[i] && !any_edge[i] && $rose(pad_lvl[i]))
            |=> (!irq_mode[i] || !edge_mode[i] || irq_status[i]));

        // R2: a falling edge sets the status of an active-low edge line
        p_fall_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && edge_mode[i] && act_low[i] && $fell(pad_lvl[i]))
            |=> (!irq_mode[i] || !edge_mode[i] || irq_status[i]));

        // R3: both-edge mode sets on any change of level
        p_any_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && edge_mode[i] && any_edge[i] && !$stable(pad_lvl[i]))
            |=> (!irq_mode[i] || !edge_mode[i] || irq_status[i]));

        // R4: a latched status holds when no clear is sampled
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && edge_mode[i] && irq_status[i] && !clr_pulse[i])
            |=> (!irq_mode[i] || !edge_mode[i] || irq_status[i]));

        // R4: a clear with no level change empties the status
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && edge_mode[i] && clr_pulse[i] && $stable(pad_lvl[i]))
            |=> (!irq_mode[i] || !edge_mode[i] || !irq_status[i]));

        // R6: a level line follows the pin with polarity applied
        p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_mode[i] && !edge_mode[i])
            |-> (irq_status[i] == (pad_lvl[i] ^ act_low[i])));

        // R7: a disabled line reports nothing
        p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_mode[i] |-> !irq_status[i]);
    end
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_lvl    (pad_lvl),
    .irq_mode   (irq_mode),
    .act_low    (act_low),
    .edge_mode  (edge_mode),
    .any_edge   (any_edge),
    .clr_pulse  (clr_pulse),
    .irq_status (irq_status)
);

// File: tb/gpio_irq_sense_bench.sv
// Bench: drives inputs on the falling edge and advances a reference model
// on each rising edge. It compares on the next falling edge, or a short
// delay after driving for combinational paths.
module gpio_irq_sense_bench;
    localparam int N          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pin, en, pol, edg, both, clr;
    logic [N-1:0] status;
    logic [N-1:0] m_latch, m_prev;
    int           tests = 0;
    int           fails = 0;
    bit           done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_irq_sense #(.LINES(N)) u_gpio_irq_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_lvl    (pin),
        .irq_mode   (en),
        .act_low    (pol),
        .edge_mode  (edg),
        .any_edge   (both),
        .clr_pulse  (clr),
        .irq_status (status)
    );

    // Next latch state from the requirements: a hit sets, a clear empties, mode gates.
    function automatic logic [N-1:0] next_latch(input logic [N-1:0] lat, prv);
        logic [N-1:0] r, f, h;
        r = pin & ~prv;
        f = ~pin & prv;
        h = (both & (r | f)) | (~both & pol & f) | (~both & ~pol & r);
        return en & edg & (h | (lat & ~clr));
    endfunction

    // Expected status from the model latch and the current inputs.
    function automatic logic [N-1:0] exp_status();
        return en & ((edg & m_latch) | (~edg & (pin ^ pol)));
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act, exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One clock: update the model on the rising edge, compare on the falling edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) m_latch = '0;
        else        m_latch = next_latch(m_latch, m_prev);
        m_prev = pin;
        @(negedge clk);
        check_vec(tag, status, exp_status());
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        m_latch = '0;
        m_prev = '0;
        en = '1; edg = '1; pol = '0; both = '0; clr = '0;
        pin = $urandom();
        @(negedge clk);
        check_vec("R8 during reset", status, '0);
        cyc("R8 reset");
        pin = ~pin;
        cyc("R8 reset toggle");
        rst_n = 1'b1;
        cyc("R8 first cycle");
        pin = '0;
        cyc("R8 settle");

        // R1: rising edge on line 0
        pin[0] = 1'b1;
        cyc("R1 vector");
        check_bit("R1 rise sets", status[0], 1'b1);
        // R4: hold through a falling change, then clear
        pin[0] = 1'b0;
        cyc("R4 vector");
        check_bit("R4 holds", status[0], 1'b1);
        clr[0] = 1'b1;
        cyc("R4 vector clr");
        clr[0] = 1'b0;
        check_bit("R4 clear", status[0], 1'b0);

        // R2: active-low edge on line 1
        pol[1] = 1'b1;
        pin[1] = 1'b1;
        cyc("R2 vector");
        check_bit("R2 rise ignored", status[1], 1'b0);
        pin[1] = 1'b0;
        cyc("R2 vector fall");
        check_bit("R2 fall sets", status[1], 1'b1);

        // R3: both edges on line 2, polarity set to 1
        both[2] = 1'b1;
        pol[2] = 1'b1;
        pin[2] = 1'b1;
        cyc("R3 vector");
        check_bit("R3 rise sets", status[2], 1'b1);
        clr[2] = 1'b1;
        cyc("R3 vector clr");
        clr[2] = 1'b0;
        check_bit("R3 cleared", status[2], 1'b0);
        pin[2] = 1'b0;
        cyc("R3 vector fall");
        check_bit("R3 fall sets", status[2], 1'b1);

        // R5: edge and clear in the same cycle on line 3
        pin[3] = 1'b1;
        clr[3] = 1'b1;
        cyc("R5 vector");
        clr[3] = 1'b0;
        check_bit("R5 set wins", status[3], 1'b1);

        // R6: level line 4
        edg[4] = 1'b0;
        pin[4] = 1'b1;
        #1 check_bit("R6 same cycle", status[4], 1'b1);
        cyc("R6 vector");
        clr[4] = 1'b1;
        cyc("R6 vector clr");
        clr[4] = 1'b0;
        check_bit("R6 clear no effect", status[4], 1'b1);
        pol[4] = 1'b1;
        #1 check_bit("R6 polarity", status[4], 1'b0);
        cyc("R6 vector pol");

        // R7: disable line 5 while latched, toggle, then re-enable
        pin[5] = 1'b1;
        cyc("R7 vector");
        check_bit("R7 latched", status[5], 1'b1);
        en[5] = 1'b0;
        #1 check_bit("R7 off gates", status[5], 1'b0);
        cyc("R7 vector off");
        pin[5] = 1'b0;
        cyc("R7 vector off lo");
        pin[5] = 1'b1;
        cyc("R7 vector off hi");
        en[5] = 1'b1;
        cyc("R7 vector on");
        check_bit("R7 no stale edge", status[5], 1'b0);

        // Random traffic covering R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 3000; k++) begin
            pin  = $urandom();
            clr  = $urandom() & $urandom();
            if (k % 50 == 0) begin
                en   = $urandom() | $urandom();
                edg  = $urandom();
                pol  = $urandom();
                both = $urandom();
            end
            #1 check_vec("R6 R7 random comb", status, exp_status());
            cyc("R1 R2 R3 R4 R5 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule